// File: doc/BRIEF.md
# Single-Channel Block DMA Engine

This block is one DMA channel that moves a run of 32-bit words between system memory and a peripheral data port. Software loads an address register, a block register whose two 16-bit halves give a block count and a block length, and a control register. Writing an exact recognised command value to the control register while the channel is idle starts the run. The channel then issues one memory access per word, reading memory and pushing the word to the device, or taking a word from the device and writing it to memory.

Each word advances the address register by four bytes. When the last word has been accepted, the channel clears its busy flag (control bit 24) and pulses its interrupt. A command value that is not recognised, or a block register whose halves multiply to zero, moves no data. It completes at once, and the interrupt is still raised.

Top module: `dma_block_chan`

## Requirements
- R1: A control write while idle clears the two low bits of the address register in the same edge, and the transfer runs from that word-aligned address.
- R2: The number of words moved equals block[31:16] multiplied by block[15:0].
- R3: Control value 0x01000201 starts a memory-to-device run: memory reads (mem_we=0) at ascending addresses, each read word presented on dev_wdata with dev_push high in the accepting cycle.
- R4: Control value 0x01000200 starts a device-to-memory run: memory writes (mem_we=1) carrying dev_rdata, with dev_pop high in each accepting cycle.
- R5: Any other control value written while idle makes no memory access, is stored with bit 24 cleared, and pulses irq in the cycle after the write.
- R6: Each accepted word (mem_valid and mem_ready) adds 4 to the address register, so at completion it holds the aligned start plus 4 times the word count.
- R7: At completion, control bit 24 reads 0 and irq is high for exactly the one cycle after the last word is accepted.
- R8: A recognised command with a zero word count makes no memory access, is stored with bit 24 cleared, and pulses irq in the cycle after the write.
- R9: While busy, writes to the address register (reg_sel=0) and the block register (reg_sel=1) have no effect.
- R10: While busy, a control write with bit 24 clear stops the run at once with no interrupt and stores the written value; a control write with bit 24 set is ignored.
- R11: After reset the address, block and control registers read zero, and irq and mem_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 address, 1 block, 2 control |
| reg_wdata | input | 32 | Register write data |
| addr_reg | output | ADDR_W | Current address register |
| blk_reg | output | 32 | Block register |
| ctrl_reg | output | 32 | Control register, bit 24 busy |
| irq | output | 1 | Completion pulse |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| dev_ready | input | 1 | Device can take a word or has one |
| dev_rdata | input | DATA_W | Word offered by the device |
| dev_wdata | output | DATA_W | Word pushed to the device |
| dev_push | output | 1 | Word handed to the device this cycle |
| dev_pop | output | 1 | Device word consumed this cycle |

## Verification
Random runs mix both directions, block shapes from 1x1 up to 4x8, unaligned start addresses and random stalls on both memory and device readiness. These runs separate a correct block-count product and address stepping from off-by-one or wrong-field errors. Directed cases cover a zero block length against a zero block count, an unrecognised command against the two valid ones, register writes during a long run, and an abort against a busy-set control write. Together they show whether the busy gating and the immediate-completion path are kept apart.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_W      = 32;
  localparam int FIELD_W    = 16;
  localparam int CNT_W      = 2 * FIELD_W;
  localparam int BUSY_BIT   = 24;
  localparam int WORD_BYTES = 4;
  localparam logic [REG_W-1:0] CMD_TO_DEV   = 32'h0100_0201;
  localparam logic [REG_W-1:0] CMD_FROM_DEV = 32'h0100_0200;

  typedef enum logic [1:0] {XF_NONE, XF_TO_DEV, XF_FROM_DEV} xfer_e;

  function automatic xfer_e classify(input logic [REG_W-1:0] w);
    if (w == CMD_TO_DEV) return XF_TO_DEV;
    if (w == CMD_FROM_DEV) return XF_FROM_DEV;
    return XF_NONE;
  endfunction

  function automatic logic [CNT_W-1:0] block_words(input logic [REG_W-1:0] b);
    return CNT_W'(b[REG_W-1:FIELD_W]) * CNT_W'(b[FIELD_W-1:0]);
  endfunction
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_chan_pkg::*;
(
  input  logic [REG_W-1:0] cmd_word,
  input  logic [REG_W-1:0] blk_word,
  output xfer_e            kind,
  output logic [CNT_W-1:0] words,
  output logic             words_zero
);
  always_comb begin
    kind       = classify(cmd_word);
    words      = block_words(blk_word);
    words_zero = (words == '0);
  end
endmodule

// File: rtl/dma_word_counter.sv
module dma_word_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             clear,
  output logic             active,
  output logic             last_step
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (clear)  rem_q <= '0;
    else if (load)   rem_q <= load_val;
    else if (step && active) rem_q <= rem_q - CNT_W'(1);
  end

  assign active    = (rem_q != '0);
  assign last_step = step && (rem_q == CNT_W'(1));
endmodule

// File: rtl/dma_block_chan.sv
module dma_block_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [ADDR_W-1:0] addr_reg,
  output logic [31:0]       blk_reg,
  output logic [31:0]       ctrl_reg,
  output logic              irq,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_ready,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_push,
  output logic              dev_pop
);
  localparam logic [REG_W-1:0]  BUSY_MASK = REG_W'(1) << BUSY_BIT;
  localparam logic [ADDR_W-1:0] STRIDE    = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  blk_q, ctrl_q;
  logic              irq_q;
  xfer_e             xfer_q;

  // named internal events
  logic              busy, wr_addr, wr_blk, wr_ctrl, idle_ctrl;
  logic              start_ok, finish_now, abort_run, beat, last_beat, cnt_active;
  xfer_e             dec_kind;
  logic [CNT_W-1:0]  dec_words;
  logic              dec_zero;

  dma_cmd_decode u_dec (
    .cmd_word  (reg_wdata),
    .blk_word  (blk_q),
    .kind      (dec_kind),
    .words     (dec_words),
    .words_zero(dec_zero)
  );

  dma_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_val (dec_words),
    .step     (beat),
    .clear    (abort_run),
    .active   (cnt_active),
    .last_step(last_beat)
  );

  assign busy       = ctrl_q[BUSY_BIT];
  assign wr_addr    = reg_wr && (reg_sel == 2'd0) && !busy;
  assign wr_blk     = reg_wr && (reg_sel == 2'd1) && !busy;
  assign wr_ctrl    = reg_wr && (reg_sel == 2'd2);
  assign idle_ctrl  = wr_ctrl && !busy;
  assign start_ok   = idle_ctrl && (dec_kind != XF_NONE) && !dec_zero;
  assign finish_now = idle_ctrl && ((dec_kind == XF_NONE) || dec_zero);
  assign abort_run  = wr_ctrl && busy && !reg_wdata[BUSY_BIT];

  assign mem_valid  = busy && cnt_active && dev_ready;
  assign mem_we     = (xfer_q == XF_FROM_DEV);
  assign mem_addr   = addr_q;
  assign mem_wdata  = dev_rdata;
  assign dev_wdata  = mem_rdata;
  assign beat       = mem_valid && mem_ready;
  assign dev_push   = beat && (xfer_q == XF_TO_DEV);
  assign dev_pop    = beat && (xfer_q == XF_FROM_DEV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      blk_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
      xfer_q <= XF_NONE;
    end else begin
      if (wr_addr)        addr_q <= reg_wdata[ADDR_W-1:0];
      else if (idle_ctrl) addr_q <= {addr_q[ADDR_W-1:2], 2'b00};
      else if (beat)      addr_q <= addr_q + STRIDE;

      if (wr_blk) blk_q <= reg_wdata;

      if (idle_ctrl)      ctrl_q <= start_ok ? reg_wdata : (reg_wdata & ~BUSY_MASK);
      else if (abort_run) ctrl_q <= reg_wdata;
      else if (last_beat) ctrl_q[BUSY_BIT] <= 1'b0;

      if (start_ok) xfer_q <= dec_kind;

      irq_q <= finish_now || last_beat;
    end
  end

  assign addr_reg = addr_q;
  assign blk_reg  = blk_q;
  assign ctrl_reg = ctrl_q;
  assign irq      = irq_q;
endmodule

// File: rtl/dma_block_chan_chk.sv
module dma_block_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [ADDR_W-1:0] addr_reg,
  input logic [31:0]       blk_reg,
  input logic [31:0]       ctrl_reg,
  input logic              irq,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_ready,
  input logic              dev_push,
  input logic              dev_pop
);
  AST_ALIGNED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reg[24] |-> (addr_reg[1:0] == 2'b00)); // R1

  AST_DIR_TO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    dev_push |-> (mem_valid && mem_ready && !mem_we)); // R3

  AST_DIR_FROM_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_we == (ctrl_reg[0] == 1'b0))); // R4

  AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_reg[24] |-> !mem_valid); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (addr_reg == $past(addr_reg) + ADDR_W'(4))); // R6

  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ctrl_reg[24]); // R7

  AST_BLK_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_reg[24] && reg_wr && reg_sel == 2'd1) |=> $stable(blk_reg)); // R9

  AST_POP_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_pop |-> (mem_valid && mem_ready && mem_we)); // R4
endmodule

bind dma_block_chan dma_block_chan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .addr_reg(addr_reg), .blk_reg(blk_reg), .ctrl_reg(ctrl_reg), .irq(irq),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_ready(mem_ready),
  .dev_push(dev_push), .dev_pop(dev_pop)
);

// File: tb/sim_dma_block_chan.sv
module sim_dma_block_chan;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TO_DEV   = 32'h0100_0201;
  localparam logic [31:0] FROM_DEV = 32'h0100_0200;
  localparam logic [31:0] BUSYM    = 32'h0100_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] addr_reg, blk_reg, ctrl_reg, mem_addr, mem_wdata, mem_rdata, dev_rdata, dev_wdata;
  logic        irq, mem_valid, mem_we, dev_push, dev_pop;
  logic        mem_ready = 1'b0, dev_ready = 1'b0;

  int n_chk = 0, n_bad = 0;
  int ncyc = 0, beats_seen = 0, last_beat_cyc = -10;
  logic        exp_active = 1'b0, exp_we = 1'b0;
  logic [31:0] exp_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic int words_of(input logic [31:0] b);
    return int'(b[31:16]) * int'(b[15:0]);
  endfunction

  assign mem_rdata = pat(mem_addr);
  assign dev_rdata = 32'hD000_0000 + beats_seen;

  dma_block_chan u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // beat monitor
  initial forever begin
    @(negedge clk);
    ncyc++;
    if (mem_valid && mem_ready) begin
      chk(exp_active, "R5/R8 unexpected access", mem_addr, 32'h0);
      chk(mem_addr == exp_addr, "R6 beat address", mem_addr, exp_addr);
      chk(mem_we == exp_we, "R3/R4 direction", {31'd0, mem_we}, {31'd0, exp_we});
      if (exp_we) begin
        chk(dev_pop && mem_wdata == 32'hD000_0000 + beats_seen, "R4 device word to memory", mem_wdata, 32'hD000_0000 + beats_seen);
      end else begin
        chk(dev_push && dev_wdata == pat(mem_addr), "R3 memory word to device", dev_wdata, pat(mem_addr));
      end
      exp_addr = exp_addr + 4;
      beats_seen++;
      last_beat_cyc = ncyc;
    end
  end

  // readiness noise
  initial forever begin
    @(posedge clk); #1;
    mem_ready = ($urandom % 4) != 0;
    dev_ready = ($urandom % 5) != 0;
  end

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic sample();
    @(negedge clk); #2;
  endtask

  task automatic start_xfer(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    write_reg(2'd0, a);
    write_reg(2'd1, b);
    exp_addr   = {a[31:2], 2'b00};
    exp_we     = (c == FROM_DEV);
    beats_seen = 0;
    exp_active = ((c == TO_DEV) || (c == FROM_DEV)) && (words_of(b) != 0);
    write_reg(2'd2, c);
  endtask

  task automatic finish_xfer(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    int n = words_of(b);
    logic [31:0] base = {a[31:2], 2'b00};
    if (!exp_active) begin
      sample();
      chk(irq == 1'b1, "R5/R8 immediate irq", {31'd0, irq}, 32'd1);
      chk(ctrl_reg == (c & ~BUSYM), "R5/R8 stored control", ctrl_reg, c & ~BUSYM);
      chk(addr_reg == base, "R1 aligned address", addr_reg, base);
      sample();
      chk(irq == 1'b0, "R5/R8 irq single", {31'd0, irq}, 32'd0);
      chk(beats_seen == 0, "R5/R8 no access", beats_seen, 0);
    end else begin
      int t = 0;
      sample();
      while (!irq && t < 20000) begin sample(); t++; end
      chk(irq == 1'b1, "R7 irq seen", {31'd0, irq}, 32'd1);
      chk(beats_seen == n, "R2 word count", beats_seen, n);
      chk(ncyc == last_beat_cyc + 1, "R7 irq timing", ncyc, last_beat_cyc + 1);
      chk(ctrl_reg == (c & ~BUSYM), "R7 busy cleared", ctrl_reg, c & ~BUSYM);
      chk(addr_reg == base + 4 * n, "R6 final address", addr_reg, base + 4 * n);
      exp_active = 1'b0;
      sample();
      chk(irq == 1'b0, "R7 irq single cycle", {31'd0, irq}, 32'd0);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    start_xfer(a, b, c);
    finish_xfer(a, b, c);
  endtask

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    sample();
    chk(addr_reg == 0 && blk_reg == 0 && ctrl_reg == 0, "R11 reset regs", ctrl_reg, 32'h0);
    chk(!irq && !mem_valid, "R11 reset outputs", {30'd0, irq, mem_valid}, 32'd0);

    run(32'h0000_0103, 32'h0002_0003, TO_DEV);    // R1 R2 R3
    run(32'h0000_0402, 32'h0003_0002, FROM_DEV);  // R4
    run(32'h0000_0800, 32'h0001_0004, 32'h0100_0202); // R5
    run(32'h0000_0A01, 32'h0004_0000, TO_DEV);    // R8 zero length
    run(32'h0000_0B00, 32'h0000_0005, FROM_DEV);  // R8 zero count
    run(32'h0000_0C00, 32'h0001_0001, TO_DEV);    // single word

    for (int i = 0; i < 10; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = {16'(1 + $urandom % 4), 16'(1 + $urandom % 8)};
      run(a, b, ($urandom % 2) ? TO_DEV : FROM_DEV);
    end

    // R9 / R10: writes during a busy run
    start_xfer(32'h0000_1000, 32'h0001_003C, TO_DEV);
    write_reg(2'd0, 32'hDEAD_0000);
    write_reg(2'd1, 32'h0005_0005);
    write_reg(2'd2, FROM_DEV);
    chk(blk_reg == 32'h0001_003C, "R9 block write ignored", blk_reg, 32'h0001_003C);
    chk(ctrl_reg == TO_DEV, "R10 busy-set write ignored", ctrl_reg, TO_DEV);
    finish_xfer(32'h0000_1000, 32'h0001_003C, TO_DEV);

    // R10 abort
    start_xfer(32'h0000_2003, 32'h0002_0064, FROM_DEV);
    repeat (10) @(negedge clk);
    write_reg(2'd2, 32'h0000_0200);
    sample();
    chk(ctrl_reg == 32'h0000_0200, "R10 abort stores value", ctrl_reg, 32'h0000_0200);
    chk(!mem_valid, "R10 abort stops access", {31'd0, mem_valid}, 32'd0);
    chk(addr_reg == 32'h2000 + 4 * beats_seen, "R10 abort address", addr_reg, 32'h2000 + 4 * beats_seen);
    chk(beats_seen < 200, "R10 abort early", beats_seen, 200);
    exp_active = 1'b0;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 12; k++) begin sample(); if (irq) seen = 1'b1; end
      chk(!seen, "R10 abort no irq", {31'd0, seen}, 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule